// File: doc/BRIEF.md
# Two-Slot Packet Fetch and Issue Front End

This block is the front end of a 32-bit processor whose compiler builds fixed two-instruction packets. Each cycle it presents the program counter on an instruction memory port, takes back a 64-bit packet, and splits it into two positional slots. The slot at the lower address goes to an arithmetic/branch lane. The slot at the higher address goes to a load/store lane. Each slot is classified, and its lane receives the instruction with a valid flag one cycle after the fetch.

The compiler is trusted to keep the two slots, and successive packets, free of dependences. The block therefore never inserts bubbles for data or resource conflicts. It suppresses empty (nop) slots and squashes packets whose slots hold the wrong instruction class. It stops issuing when the fetch address is not packet aligned. A taken-branch redirect reloads the program counter and throws away the packet in flight. A stall freezes the whole front end. A counter accumulates the number of instructions actually handed to the lanes.

Top module: `dual_issue_front`

## Requirements
- R1: While rst_n is low at a clock edge, the block sets the program counter (imem_addr) to 0. It clears alu_valid, mem_valid, illegal_pkt and misalign, and sets issue_count to 0.
- R2: imem_addr always equals the program counter. On an edge with no reset, redirect, stall or misalignment, the counter grows by 8. The lane outputs and issue_pc then show the packet fetched at the old address, one cycle after it was presented.
- R3: Slot 0 is imem_rdata[31:0], the lower address, and feeds alu_instr. Slot 1 is imem_rdata[63:32] and feeds mem_instr.
- R4: Slots are classified as follows. An all-zero word is a nop. bits[31:30] = 2'b10 is load/store. bits[31:29] = 3'b111 is reserved. Any other nonzero word is arithmetic/branch.
- R5: A nop in either slot leaves that lane's valid flag low and does not raise illegal_pkt.
- R6: illegal_pkt rises, and both lanes are invalid for that packet, in either of two cases. Slot 0 is load/store or reserved. Slot 1 is arithmetic/branch or reserved.
- R7: There is no dependence checking. A legal packet whose two slots name the same register issues both lanes in one cycle, and back-to-back packets issue with no bubble.
- R8: A fetch address with a nonzero value in bits [2:0] raises misalign and issues nothing. The program counter then holds that address until a redirect.
- R9: On the edge after redirect_valid, imem_addr equals redirect_target. Both lanes are invalid, so the packet already fetched is discarded. illegal_pkt and misalign are low and issue_count is unchanged. A redirect takes priority over stall.
- R10: stall without redirect holds imem_addr, every lane output, both flags and issue_count.
- R11: On each loading edge, issue_count grows by the number of lanes made valid, which is 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Freeze program counter and lane outputs |
| redirect_valid | input | 1 | Taken-branch redirect request |
| redirect_target | input | 32 | Redirect destination address |
| imem_addr | output | 32 | Instruction memory fetch address (program counter) |
| imem_rdata | input | 64 | Packet returned for imem_addr in the same cycle |
| alu_valid | output | 1 | Arithmetic/branch lane holds an instruction |
| alu_instr | output | 32 | Arithmetic/branch lane instruction |
| mem_valid | output | 1 | Load/store lane holds an instruction |
| mem_instr | output | 32 | Load/store lane instruction |
| issue_pc | output | 32 | Address of the packet shown on the lanes |
| illegal_pkt | output | 1 | Shown packet had a slot of the wrong class |
| misalign | output | 1 | Last fetch address was not 8-byte aligned |
| issue_count | output | 16 | Running count of issued instructions |

## Verification
A redirect can arrive in the same cycle as a stall, or while the front end is stuck on a misaligned address. The bench raises stall and redirect_valid together and expects the redirect to win: the new address appears, both lanes are empty and the count does not move. It also redirects to an unaligned target and expects misalign to hold with the address frozen over two cycles. A second redirect must then clear the flag and restart normal issue.

// File: rtl/dual_issue_pkg.sv
// Shared types for the two-slot packet front end.
// Assumes: instruction class is decided from the upper opcode bits only.
package dual_issue_pkg;

    // Class of one instruction slot
    typedef enum logic [1:0] {
        CLS_NOP = 2'd0,
        CLS_ALU = 2'd1,
        CLS_MEM = 2'd2,
        CLS_BAD = 2'd3
    } slot_class_e;

    localparam int NUM_SLOTS = 2;

endpackage

// File: rtl/slot_classifier.sv
// Classifies a single instruction word into nop, arithmetic/branch,
// load/store or reserved.
// Assumes: all-zero word is the nop; bits[top:top-1]=10 is load/store;
// bits[top:top-2]=111 is reserved; anything else is arithmetic/branch.
module slot_classifier
    import dual_issue_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] instr,
    output slot_class_e     cls
);

    localparam int TOP = XLEN - 1;

    // Decode the class from the opcode field
    always_comb begin
        if (instr == '0)
            cls = CLS_NOP;
        else if (instr[TOP -: 2] == 2'b10)
            cls = CLS_MEM;
        else if (instr[TOP -: 3] == 3'b111)
            cls = CLS_BAD;
        else
            cls = CLS_ALU;
    end

endmodule

// File: rtl/fetch_pc.sv
// Program counter for packet fetch: steps by one packet, reloads on a
// redirect, freezes on stall or on a misaligned address.
// Assumes: redirect outranks stall; a misaligned PC is held until a redirect.
module fetch_pc #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic            redirect_valid,
    input  logic [XLEN-1:0] redirect_target,
    output logic [XLEN-1:0] pc,
    output logic            pc_misaligned
);

    localparam int PKT_BYTES  = (2 * XLEN) / 8;
    localparam int ALIGN_BITS = $clog2(PKT_BYTES);

    // Flag an address that is not on a packet boundary
    always_comb pc_misaligned = (pc[ALIGN_BITS-1:0] != '0);

    // Advance, reload or hold the program counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (redirect_valid)
            pc <= redirect_target;
        else if (stall || pc_misaligned)
            pc <= pc;
        else
            pc <= pc + XLEN'(PKT_BYTES);
    end

endmodule

// File: rtl/issue_regs.sv
// Lane output registers and issue counter. Checks slot classes by
// position, suppresses nops, squashes illegal or misaligned packets.
// Assumes: no dependence checking of any kind; the compiler guarantees it.
module issue_regs
    import dual_issue_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              redirect_valid,
    input  logic              pc_misaligned,
    input  logic [XLEN-1:0]   pc,
    input  logic [2*XLEN-1:0] packet,
    input  slot_class_e       cls0,
    input  slot_class_e       cls1,
    output logic              alu_valid,
    output logic [XLEN-1:0]   alu_instr,
    output logic              mem_valid,
    output logic [XLEN-1:0]   mem_instr,
    output logic [XLEN-1:0]   issue_pc,
    output logic              illegal_pkt,
    output logic              misalign,
    output logic [CNT_W-1:0]  issue_count
);

    logic slot0_ok;
    logic slot1_ok;
    logic pkt_legal;
    logic nxt_alu_v;
    logic nxt_mem_v;

    // Positional legality and next-cycle lane valids
    always_comb begin
        slot0_ok  = (cls0 == CLS_NOP) || (cls0 == CLS_ALU);
        slot1_ok  = (cls1 == CLS_NOP) || (cls1 == CLS_MEM);
        pkt_legal = slot0_ok && slot1_ok;
        nxt_alu_v = !pc_misaligned && pkt_legal && (cls0 == CLS_ALU);
        nxt_mem_v = !pc_misaligned && pkt_legal && (cls1 == CLS_MEM);
    end

    // Load, clear or hold the lane registers and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alu_valid   <= 1'b0;
            mem_valid   <= 1'b0;
            alu_instr   <= '0;
            mem_instr   <= '0;
            issue_pc    <= '0;
            illegal_pkt <= 1'b0;
            misalign    <= 1'b0;
            issue_count <= '0;
        end else if (redirect_valid) begin
            alu_valid   <= 1'b0;
            mem_valid   <= 1'b0;
            alu_instr   <= '0;
            mem_instr   <= '0;
            illegal_pkt <= 1'b0;
            misalign    <= 1'b0;
        end else if (!stall) begin
            alu_valid   <= nxt_alu_v;
            mem_valid   <= nxt_mem_v;
            alu_instr   <= pc_misaligned ? '0 : packet[XLEN-1:0];
            mem_instr   <= pc_misaligned ? '0 : packet[2*XLEN-1:XLEN];
            issue_pc    <= pc;
            illegal_pkt <= !pc_misaligned && !pkt_legal;
            misalign    <= pc_misaligned;
            issue_count <= issue_count + CNT_W'(nxt_alu_v) + CNT_W'(nxt_mem_v);
        end
    end

endmodule

// File: rtl/dual_issue_front.sv
// Top of the two-slot packet front end: program counter, one class
// decoder per slot, and the lane output stage.
// Assumes: imem_rdata answers imem_addr combinationally in the same cycle.
module dual_issue_front
    import dual_issue_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              redirect_valid,
    input  logic [XLEN-1:0]   redirect_target,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [2*XLEN-1:0] imem_rdata,
    output logic              alu_valid,
    output logic [XLEN-1:0]   alu_instr,
    output logic              mem_valid,
    output logic [XLEN-1:0]   mem_instr,
    output logic [XLEN-1:0]   issue_pc,
    output logic              illegal_pkt,
    output logic              misalign,
    output logic [CNT_W-1:0]  issue_count
);

    logic [XLEN-1:0] pc;
    logic            pc_misaligned;
    slot_class_e     slot_cls [NUM_SLOTS];

    fetch_pc #(.XLEN(XLEN)) u_pc (
        .clk             (clk),
        .rst_n           (rst_n),
        .stall           (stall),
        .redirect_valid  (redirect_valid),
        .redirect_target (redirect_target),
        .pc              (pc),
        .pc_misaligned   (pc_misaligned)
    );

    // One classifier per packet slot
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        slot_classifier #(.XLEN(XLEN)) u_cls (
            .instr (imem_rdata[g*XLEN +: XLEN]),
            .cls   (slot_cls[g])
        );
    end

    issue_regs #(.XLEN(XLEN), .CNT_W(CNT_W)) u_issue (
        .clk            (clk),
        .rst_n          (rst_n),
        .stall          (stall),
        .redirect_valid (redirect_valid),
        .pc_misaligned  (pc_misaligned),
        .pc             (pc),
        .packet         (imem_rdata),
        .cls0           (slot_cls[0]),
        .cls1           (slot_cls[1]),
        .alu_valid      (alu_valid),
        .alu_instr      (alu_instr),
        .mem_valid      (mem_valid),
        .mem_instr      (mem_instr),
        .issue_pc       (issue_pc),
        .illegal_pkt    (illegal_pkt),
        .misalign       (misalign),
        .issue_count    (issue_count)
    );

    // Drive the fetch port from the program counter
    always_comb imem_addr = pc;

endmodule

// File: rtl/dual_issue_front_chk.sv
// Property checker for the two-slot front end, bound to the top.
// Assumes: same parameter values as the bound instance.
module dual_issue_front_chk #(
    parameter int XLEN  = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall,
    input logic             redirect_valid,
    input logic [XLEN-1:0]  redirect_target,
    input logic [XLEN-1:0]  imem_addr,
    input logic             alu_valid,
    input logic [XLEN-1:0]  alu_instr,
    input logic             mem_valid,
    input logic [XLEN-1:0]  mem_instr,
    input logic             illegal_pkt,
    input logic             misalign,
    input logic [CNT_W-1:0] issue_count
);

    localparam int PKT_BYTES = (2 * XLEN) / 8;

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !redirect_valid && imem_addr[2:0] == 3'b000)
        |=> (imem_addr == $past(imem_addr) + XLEN'(PKT_BYTES)));

    p_nop_suppressed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alu_valid |-> (alu_instr != '0));

    p_mem_lane_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_instr[XLEN-1 -: 2] == 2'b10 && mem_instr != '0));

    p_illegal_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_pkt |-> (!alu_valid && !mem_valid));

    p_misalign_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!alu_valid && !mem_valid && !illegal_pkt));

    p_misalign_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (misalign && !stall && !redirect_valid) |=> (misalign && $stable(imem_addr)));

    p_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (imem_addr == $past(redirect_target)
                            && !alu_valid && !mem_valid && $stable(issue_count)));

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redirect_valid) |=> ($stable(imem_addr) && $stable(alu_valid)
                                        && $stable(mem_valid) && $stable(issue_count)));

    p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !redirect_valid) |=> (issue_count == $past(issue_count)
                                         + CNT_W'(alu_valid) + CNT_W'(mem_valid)));

endmodule

bind dual_issue_front dual_issue_front_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .stall           (stall),
    .redirect_valid  (redirect_valid),
    .redirect_target (redirect_target),
    .imem_addr       (imem_addr),
    .alu_valid       (alu_valid),
    .alu_instr       (alu_instr),
    .mem_valid       (mem_valid),
    .mem_instr       (mem_instr),
    .illegal_pkt     (illegal_pkt),
    .misalign        (misalign),
    .issue_count     (issue_count)
);

// File: tb/sim_dual_issue_front.sv
// Bench for the two-slot front end: a table walk of packets, then
// directed stall, redirect, misalignment and reset tests.
module sim_dual_issue_front;

    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] ALU_I = 32'h0022_1820;
    localparam logic [31:0] LD_I  = 32'h8C41_0004;
    localparam logic [31:0] ST_I  = 32'hAC41_0008;
    localparam logic [31:0] BR_I  = 32'h1022_FFFC;
    localparam logic [31:0] RS_I  = 32'hFC00_0000;

    // {slot0, slot1, exp alu_valid, exp mem_valid, exp illegal}
    localparam logic [66:0] VEC [8] = '{
        {ALU_I, LD_I,  3'b110},
        {32'h0, ST_I,  3'b010},
        {BR_I,  32'h0, 3'b100},
        {32'h0, 32'h0, 3'b000},
        {LD_I,  LD_I,  3'b001},
        {ALU_I, ALU_I, 3'b001},
        {RS_I,  32'h0, 3'b001},
        {ALU_I, RS_I,  3'b001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        redirect_valid = 1'b0;
    logic [31:0] redirect_target = '0;
    logic [31:0] imem_addr;
    logic [63:0] imem_rdata;
    logic        alu_valid, mem_valid, illegal_pkt, misalign;
    logic [31:0] alu_instr, mem_instr, issue_pc;
    logic [15:0] issue_count;
    logic [63:0] mem [16];

    int n_cmp = 0;
    int n_bad = 0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_rdata = mem[imem_addr[6:3]];

    dual_issue_front u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .redirect_valid(redirect_valid), .redirect_target(redirect_target),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .alu_valid(alu_valid), .alu_instr(alu_instr),
        .mem_valid(mem_valid), .mem_instr(mem_instr),
        .issue_pc(issue_pc), .illegal_pkt(illegal_pkt),
        .misalign(misalign), .issue_count(issue_count)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lanes(input string tag, input logic av, input logic mv, input logic [31:0] addr);
        check({tag, " alu_valid"}, 64'(alu_valid), 64'(av));
        check({tag, " mem_valid"}, 64'(mem_valid), 64'(mv));
        check({tag, " imem_addr"}, 64'(imem_addr), 64'(addr));
        check({tag, " issue_count"}, 64'(issue_count), 64'(exp_cnt));
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++)
            mem[i] = (i < 8) ? {VEC[i][34:3], VEC[i][66:35]} : {LD_I, ALU_I};

        // R1: reset state
        tick();
        tick();
        check("R1 imem_addr", 64'(imem_addr), 64'h0);
        check("R1 alu_valid", 64'(alu_valid), 64'h0);
        check("R1 mem_valid", 64'(mem_valid), 64'h0);
        check("R1 flags", 64'({illegal_pkt, misalign}), 64'h0);
        check("R1 issue_count", 64'(issue_count), 64'h0);
        rst_n = 1'b1;

        // Table walk: R2, R3, R4, R5, R6, R11
        for (int i = 0; i < 8; i++) begin
            tick();
            exp_cnt += int'(VEC[i][2]) + int'(VEC[i][1]);
            lanes("R2 R11 walk", VEC[i][2], VEC[i][1], 32'(8 * (i + 1)));
            check("R2 issue_pc", 64'(issue_pc), 64'(8 * i));
            check("R4 R6 illegal_pkt", 64'(illegal_pkt), 64'(VEC[i][0]));
            if (VEC[i][2]) check("R3 alu_instr", 64'(alu_instr), 64'(VEC[i][66:35]));
            if (VEC[i][1]) check("R3 mem_instr", 64'(mem_instr), 64'(VEC[i][34:3]));
            if (i == 0) check("R7 dependent pair same cycle", 64'({alu_valid, mem_valid}), 64'h3);
            if (i == 1) check("R5 R7 no bubble count", 64'(issue_count), 64'd3);
        end

        // Packet at 64, then stall twice: R10
        tick();
        exp_cnt += 2;
        lanes("R2 fill", 1'b1, 1'b1, 32'd72);
        stall = 1'b1;
        for (int k = 0; k < 2; k++) begin
            tick();
            lanes("R10 stall", 1'b1, 1'b1, 32'd72);
            check("R10 issue_pc", 64'(issue_pc), 64'd64);
            check("R10 alu_instr", 64'(alu_instr), 64'(ALU_I));
        end

        // Redirect discards the in-flight packet: R9
        stall = 1'b0;
        redirect_valid = 1'b1;
        redirect_target = 32'd16;
        tick();
        lanes("R9 redirect", 1'b0, 1'b0, 32'd16);
        redirect_valid = 1'b0;
        tick();
        exp_cnt += 1;
        lanes("R9 after redirect", 1'b1, 1'b0, 32'd24);
        check("R9 issue_pc", 64'(issue_pc), 64'd16);

        // Redirect and stall together: redirect wins (R9)
        stall = 1'b1;
        redirect_valid = 1'b1;
        redirect_target = 32'd0;
        tick();
        lanes("R9 redirect over stall", 1'b0, 1'b0, 32'd0);
        stall = 1'b0;
        redirect_valid = 1'b0;
        tick();
        exp_cnt += 2;
        lanes("R9 resume", 1'b1, 1'b1, 32'd8);
        check("R9 resume issue_pc", 64'(issue_pc), 64'd0);

        // Misaligned target: R8
        redirect_valid = 1'b1;
        redirect_target = 32'd12;
        tick();
        lanes("R8 load bad target", 1'b0, 1'b0, 32'd12);
        check("R8 misalign before fetch", 64'(misalign), 64'h0);
        redirect_valid = 1'b0;
        for (int k = 0; k < 2; k++) begin
            tick();
            lanes("R8 misaligned", 1'b0, 1'b0, 32'd12);
            check("R8 misalign", 64'(misalign), 64'h1);
        end
        redirect_valid = 1'b1;
        redirect_target = 32'd8;
        tick();
        check("R8 R9 misalign cleared", 64'(misalign), 64'h0);
        lanes("R8 recover", 1'b0, 1'b0, 32'd8);
        redirect_valid = 1'b0;
        tick();
        exp_cnt += 1;
        lanes("R8 recovered issue", 1'b0, 1'b1, 32'd16);
        check("R8 recovered mem_instr", 64'(mem_instr), 64'(ST_I));

        // Reset mid-run: R1
        rst_n = 1'b0;
        tick();
        exp_cnt = 0;
        lanes("R1 mid-run reset", 1'b0, 1'b0, 32'd0);
        check("R1 mid-run flags", 64'({illegal_pkt, misalign}), 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule